// File: doc/BRIEF.md
# Two-Write Two-Read Register File

This block holds the general-purpose operand registers of a five-stage in-order pipeline. The decode stage reads two source operands in one cycle through read ports A and B. Both ports are combinational: each takes a register index and returns that register's contents in the same cycle. Write-back can commit two results per cycle. The execute-result port (E) carries values computed by the arithmetic/logic unit. The memory-result port (M) carries values loaded from data memory.

The two write ports can name the same register in the same cycle. In that case the memory-result value is stored. A read can name a register that is being written in the same cycle. In that case the read returns the value being written, so decode sees the result without waiting a cycle. The same M-over-E priority applies to this bypass. Forwarding from later pipeline registers and hazard detection are handled elsewhere.

Top module: `regfile_2w2r`

## Requirements
- R1: While `rst_n` is low, and after its release, every register reads as zero until it is written. Reset is asynchronous and active low.
- R2: With `e_wen` high at a rising clock edge, register `e_widx` holds `e_wdata` from that edge on.
- R3: With `m_wen` high at a rising clock edge, register `m_widx` holds `m_wdata` from that edge on.
- R4: Both write ports can be enabled in the same cycle with different indices. Both registers are then updated at that edge.
- R5: When both ports are enabled with the same index, the register stores `m_wdata`.
- R6: A read whose index equals an enabled write index in the same cycle returns that write's data, not the stored value.
- R7: When both ports write the index a read names in the same cycle, the read returns `m_wdata`.
- R8: A write port with its enable low changes no register, whatever its index and data hold. It also supplies no bypass data.
- R9: Read ports A and B work independently. They return correct values whether their indices are the same or differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| e_wen | input | 1 | Execute-result write enable |
| e_widx | input | 4 | Execute-result register index |
| e_wdata | input | 32 | Execute-result data |
| m_wen | input | 1 | Memory-result write enable |
| m_widx | input | 4 | Memory-result register index |
| m_wdata | input | 32 | Memory-result data |
| a_ridx | input | 4 | Read port A index |
| a_rdata | output | 32 | Read port A data |
| b_ridx | input | 4 | Read port B index |
| b_rdata | output | 32 | Read port B data |

## Verification
Two functions can meet in one cycle. The first is the write conflict, where E and M target the same register. The second is the read bypass, where a read names a register being written; when it meets the conflict, the bypass must resolve the same way. Both are provoked by directed cycles that aim E, M and a read at one index. Random traffic is confined at times to four indices so that collisions are frequent. The read data in the colliding cycle is compared with a bench model that gives M priority. A read of the same register in the next cycle, with no further write to it, must return the M value that was stored.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Source chosen for a register entry or a read result in one cycle.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_EXEC = 2'd1,
    SRC_MEM  = 2'd2
  } rf_src_e;
endpackage

// File: rtl/rf_src_sel.sv
module rf_src_sel
  import rf_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic             e_wen,
  input  logic [IDX_W-1:0] e_widx,
  input  logic             m_wen,
  input  logic [IDX_W-1:0] m_widx,
  output rf_src_e          src
);
  logic e_hit;
  logic m_hit;

  assign e_hit = e_wen && (e_widx == tgt_idx);
  assign m_hit = m_wen && (m_widx == tgt_idx);

  // The memory-result port outranks the execute-result port.
  always_comb begin
    if (m_hit)      src = SRC_MEM;
    else if (e_hit) src = SRC_EXEC;
    else            src = SRC_HOLD;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_wen,
  input  logic [IDX_W-1:0]  e_widx,
  input  logic [DATA_W-1:0] e_wdata,
  input  logic              m_wen,
  input  logic [IDX_W-1:0]  m_widx,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] regs_q [NUM_REGS]
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    localparam logic [IDX_W-1:0] ENTRY_IDX = IDX_W'(g);

    rf_src_e           sel;
    logic              ld_en;
    logic [DATA_W-1:0] d_next;

    rf_src_sel #(.IDX_W(IDX_W)) u_sel (
      .tgt_idx (ENTRY_IDX),
      .e_wen   (e_wen),
      .e_widx  (e_widx),
      .m_wen   (m_wen),
      .m_widx  (m_widx),
      .src     (sel)
    );

    always_comb begin
      ld_en  = 1'b0;
      d_next = regs_q[g];
      unique case (sel)
        SRC_MEM:  begin ld_en = 1'b1; d_next = m_wdata; end
        SRC_EXEC: begin ld_en = 1'b1; d_next = e_wdata; end
        default:  begin ld_en = 1'b0; d_next = regs_q[g]; end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (ld_en) regs_q[g] <= d_next;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]  ridx,
  input  logic [DATA_W-1:0] regs_q [NUM_REGS],
  input  logic              e_wen,
  input  logic [IDX_W-1:0]  e_widx,
  input  logic [DATA_W-1:0] e_wdata,
  input  logic              m_wen,
  input  logic [IDX_W-1:0]  m_widx,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] rdata
);
  rf_src_e sel;

  rf_src_sel #(.IDX_W(IDX_W)) u_sel (
    .tgt_idx (ridx),
    .e_wen   (e_wen),
    .e_widx  (e_widx),
    .m_wen   (m_wen),
    .m_widx  (m_widx),
    .src     (sel)
  );

  // Write-through bypass, with the same priority as the storage update.
  always_comb begin
    unique case (sel)
      SRC_MEM:  rdata = m_wdata;
      SRC_EXEC: rdata = e_wdata;
      default:  rdata = regs_q[ridx];
    endcase
  end
endmodule

// File: rtl/regfile_2w2r.sv
module regfile_2w2r #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_wen,
  input  logic [IDX_W-1:0]  e_widx,
  input  logic [DATA_W-1:0] e_wdata,
  input  logic              m_wen,
  input  logic [IDX_W-1:0]  m_widx,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [IDX_W-1:0]  a_ridx,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [IDX_W-1:0]  b_ridx,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int NUM_RD = 2;

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [IDX_W-1:0]  rd_idx  [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];

  assign rd_idx[0] = a_ridx;
  assign rd_idx[1] = b_ridx;
  assign a_rdata   = rd_data[0];
  assign b_rdata   = rd_data[1];

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .e_wen   (e_wen),
    .e_widx  (e_widx),
    .e_wdata (e_wdata),
    .m_wen   (m_wen),
    .m_widx  (m_widx),
    .m_wdata (m_wdata),
    .regs_q  (regs_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
      .ridx    (rd_idx[p]),
      .regs_q  (regs_q),
      .e_wen   (e_wen),
      .e_widx  (e_widx),
      .e_wdata (e_wdata),
      .m_wen   (m_wen),
      .m_widx  (m_widx),
      .m_wdata (m_wdata),
      .rdata   (rd_data[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              e_wen,
  input logic [IDX_W-1:0]  e_widx,
  input logic [DATA_W-1:0] e_wdata,
  input logic              m_wen,
  input logic [IDX_W-1:0]  m_widx,
  input logic [DATA_W-1:0] m_wdata,
  input logic [IDX_W-1:0]  a_ridx,
  input logic [DATA_W-1:0] a_rdata,
  input logic [IDX_W-1:0]  b_ridx,
  input logic [DATA_W-1:0] b_rdata
);
  logic a_quiet;
  assign a_quiet = !(e_wen && e_widx == a_ridx) && !(m_wen && m_widx == a_ridx);

  // R3: a memory-result write is visible on port A in the next cycle
  a_r3_mem_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(m_wen) && a_ridx == $past(m_widx) && a_quiet) |-> a_rdata == $past(m_wdata));

  // R2: an uncontested execute-result write is visible in the next cycle
  a_r2_exec_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(e_wen) && !($past(m_wen) && $past(m_widx) == $past(e_widx))
     && a_ridx == $past(e_widx) && a_quiet) |-> a_rdata == $past(e_wdata));

  // R7: both ports hitting the index read on B yield the memory-result data
  a_r7_bypass_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (e_wen && m_wen && e_widx == b_ridx && m_widx == b_ridx) |-> b_rdata == m_wdata);

  // R6: an execute-only hit on port B returns the data being written
  a_r6_bypass_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (e_wen && e_widx == b_ridx && !(m_wen && m_widx == b_ridx)) |-> b_rdata == e_wdata);

  // R9: both read ports agree whenever they name the same register
  a_r9_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ridx == b_ridx) |-> a_rdata == b_rdata);
endmodule

bind regfile_2w2r rf_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .e_wen   (e_wen),
  .e_widx  (e_widx),
  .e_wdata (e_wdata),
  .m_wen   (m_wen),
  .m_widx  (m_widx),
  .m_wdata (m_wdata),
  .a_ridx  (a_ridx),
  .a_rdata (a_rdata),
  .b_ridx  (b_ridx),
  .b_rdata (b_rdata)
);

// File: tb/test_regfile_2w2r.sv
`timescale 1ns/1ps
module test_regfile_2w2r;
  localparam int NR = 16;
  localparam int DW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          e_wen, m_wen;
  logic [IW-1:0] e_widx, m_widx, a_ridx, b_ridx;
  logic [DW-1:0] e_wdata, m_wdata, a_rdata, b_rdata;

  logic [DW-1:0] model [NR];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  regfile_2w2r i_regfile_2w2r (
    .clk(clk), .rst_n(rst_n),
    .e_wen(e_wen), .e_widx(e_widx), .e_wdata(e_wdata),
    .m_wen(m_wen), .m_widx(m_widx), .m_wdata(m_wdata),
    .a_ridx(a_ridx), .a_rdata(a_rdata),
    .b_ridx(b_ridx), .b_rdata(b_rdata)
  );

  // Expected read value: M bypass, then E bypass, then stored model.
  function automatic logic [DW-1:0] exp_rd(input logic [IW-1:0] idx);
    if (m_wen && m_widx == idx) return m_wdata;
    if (e_wen && e_widx == idx) return e_wdata;
    return model[idx];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ee, input logic [IW-1:0] ei, input logic [DW-1:0] ed,
                      input logic me, input logic [IW-1:0] mi, input logic [DW-1:0] md,
                      input logic [IW-1:0] ra, input logic [IW-1:0] rb, input string req);
    @(negedge clk);
    e_wen = ee; e_widx = ei; e_wdata = ed;
    m_wen = me; m_widx = mi; m_wdata = md;
    a_ridx = ra; b_ridx = rb;
    #1;
    check(req, "port A", a_rdata, exp_rd(ra));
    check(req, "port B", b_rdata, exp_rd(rb));
    @(posedge clk);
    if (m_wen) model[m_widx] = m_wdata;
    if (e_wen && !(m_wen && m_widx == e_widx)) model[e_widx] = e_wdata;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NR; i++) model[i] = '0;
    rst_n = 1'b0;
    e_wen = 0; m_wen = 0; e_widx = '0; m_widx = '0; e_wdata = '0; m_wdata = '0;
    a_ridx = '0; b_ridx = '0;
    repeat (3) @(negedge clk);
    a_ridx = 4'd5; b_ridx = 4'd12; #1;
    check("R1", "in reset A", a_rdata, '0);
    check("R1", "in reset B", b_rdata, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1: all registers zero after reset
    for (int i = 0; i < NR / 2; i++)
      step(0, 4'd0, '0, 0, 4'd0, '0, IW'(i), IW'(NR - 1 - i), "R1");

    // R2: execute-result write
    step(1, 4'd3, 32'hA5A5_0003, 0, 4'd0, '0, 4'd0, 4'd1, "R2");
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd3, 4'd3, "R2");
    // R3: memory-result write
    step(0, 4'd0, '0, 1, 4'd7, 32'h7777_0007, 4'd2, 4'd2, "R3");
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd7, 4'd3, "R3");
    // R4: both ports, different registers
    step(1, 4'd1, 32'h1111_1111, 1, 4'd2, 32'h2222_2222, 4'd0, 4'd0, "R4");
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd1, 4'd2, "R4");
    // R5: both ports, same register
    step(1, 4'd9, 32'hEEEE_0009, 1, 4'd9, 32'hDDDD_0009, 4'd0, 4'd1, "R5");
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd9, 4'd9, "R5");
    check("R5", "stored M value", a_rdata, 32'hDDDD_0009);
    // R6: bypass of in-flight writes
    step(1, 4'd4, 32'h4444_0004, 0, 4'd0, '0, 4'd4, 4'd3, "R6");
    step(0, 4'd0, '0, 1, 4'd8, 32'h8888_0008, 4'd1, 4'd8, "R6");
    // R7: bypass priority with both ports on the read index
    step(1, 4'd5, 32'hE5E5_E5E5, 1, 4'd5, 32'hD5D5_D5D5, 4'd5, 4'd5, "R7");
    // R8: disabled ports touch nothing and bypass nothing
    step(0, 4'd6, 32'hBAD0_0006, 0, 4'd6, 32'hBAD1_0006, 4'd6, 4'd6, "R8");
    step(0, 4'd9, 32'hBAD0_0009, 0, 4'd3, 32'hBAD1_0003, 4'd9, 4'd3, "R8");
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd6, 4'd9, "R8");
    check("R8", "reg 6 untouched", a_rdata, '0);
    // R9: independent ports, same and different indices
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd7, 4'd7, "R9");
    step(0, 4'd0, '0, 0, 4'd0, '0, 4'd2, 4'd1, "R9");

    // Random traffic, sometimes squeezed into four registers
    for (int n = 0; n < 600; n++) begin
      logic [IW-1:0] mask;
      mask = (n % 3 == 0) ? 4'h3 : 4'hF;
      step(1'($urandom), IW'($urandom) & mask, $urandom,
           1'($urandom), IW'($urandom) & mask, $urandom,
           IW'($urandom) & mask, IW'($urandom) & mask, "R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule